// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Sixteenth-Step Stop Period and Clear-to-Send Gating

This block turns one parallel character at a time into an asynchronous serial frame on a single line. It is paced by a one-cycle enable pulse arriving at sixteen times the bit rate, so every bit on the line spans sixteen of these pulses. A character of five to eight bits can be followed by an optional parity bit. The idle-level period that closes the frame is set in sixteenths of a bit by a 4-bit code. Character length, parity, stop code and clock mode are captured when the character is accepted.

The line driver can be slowed by a clear-to-send input, which is active low. When gating is on, the input passes through a two-stage synchroniser. It is consulted only when a captured character is about to begin. While the input reads high the line stays at the idle (high) level and the character waits. When the block is told that its pacing pulse is a 1x bit clock, each pulse is one whole bit. In that mode the stop period is one or two bits.

The upstream character queue and the rate generator sit outside this block. It takes characters through a valid/ready handshake and reports when its shifter has run empty.

Top module: `frac_stop_tx`

## Requirements
- R1: After reset, `txd` is 1, `in_ready` is 1 and `tx_empty` is 1.
- R2: A frame is a low start bit followed by the data bits, least significant first. The number of data bits is set by `char_len` (00 = 5, 01 = 6, 10 = 7, 11 = 8). In 16x mode each bit lasts 16 `tick16` pulses. `txd` changes only on a clock edge where `tick16` is high.
- R3: With `par_en` = 1 a parity bit follows the last data bit. With `par_odd` = 0 the parity bit makes the count of ones in data plus parity even; with `par_odd` = 1 it makes that count odd.
- R4: In 16x mode for 6- to 8-bit characters, the stop period in ticks is 9 + code for codes 0 to 7, and 16 + (code − 7) for codes 8 to 15.
- R5: For 5-bit characters in 16x mode, codes 0 to 7 give 8 ticks more than under R4 (17 to 24). Codes 8 to 15 are unchanged.
- R6: With `ext1x` = 1, each `tick16` pulse is one bit. The stop period is 1 tick when bit 3 of the code is 0 and 2 ticks when it is 1.
- R7: With `cts_en` = 1, the start bit begins only on a tick where the synchronised `cts_n` (two register stages) is low. Until then `txd` stays 1 and the character waits. With `cts_en` = 0, `cts_n` has no effect.
- R8: A change of `cts_n` after the start bit has begun does not alter that frame.
- R9: `in_ready` is high only when idle. A character is taken on a clock edge with `in_valid` and `in_ready` both high; `in_valid` at any other time is ignored. `tx_empty` falls on acceptance and rises, together with `in_ready`, on the tick that ends the stop period.
- R10: After acceptance, the start bit begins on the first later clock edge where `tick16` is high and R7 permits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Bit-rate pacing pulse (16x, or 1x when `ext1x`) |
| in_valid | input | 1 | Character offered |
| in_data | input | DATA_W | Character, LSB first on the line |
| in_ready | output | 1 | Idle, character can be taken |
| char_len | input | 2 | Data bits minus five |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| stop_code | input | 4 | Stop period code |
| cts_en | input | 1 | Enable clear-to-send gating |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| ext1x | input | 1 | Pacing pulse is a 1x bit clock |
| txd | output | 1 | Serial line, idle high |
| tx_empty | output | 1 | No character held or in flight |

## Verification
A wrong bit counter or stop length shows up at the line itself. An edge of `txd` lands one or more ticks away from where the frame arithmetic puts it, so a per-clock comparison catches it on the very tick it happens. A wrong state, or a wrong captured setting, is seen within one frame: `in_ready` or `tx_empty` returns on the wrong edge, or the parity or data bit differs. A broken synchroniser or gating term is seen on the first tick after the clear-to-send input changes, as a start bit that comes too early or too late.

// File: rtl/frac_tx_pkg.sv
package frac_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_DATA = 2'd2,
    ST_STOP = 2'd3
  } tx_state_t;
endpackage

// File: rtl/frac_tx_cts_sync.sv
module frac_tx_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic sync_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], pin_n};
  end

  assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/frac_tx_stop_len.sv
module frac_tx_stop_len #(
  parameter int OVS = 16,
  parameter int CW  = 5
) (
  input  logic [3:0]    code,
  input  logic          len5,
  input  logic          x1,
  output logic [CW-1:0] ticks
);
  localparam logic [CW-1:0] BASE = CW'(OVS / 2 + 1);
  localparam logic [CW-1:0] HALF = CW'(OVS / 2);

  always_comb begin
    if (x1) begin
      ticks = code[3] ? CW'(2) : CW'(1);
    end else begin
      // short codes and long codes share the same arithmetic: code + 9
      ticks = CW'(code) + BASE;
      if (len5 && !code[3]) ticks = ticks + HALF;
    end
  end
endmodule

// File: rtl/frac_tx_framer.sv
module frac_tx_framer #(
  parameter int DATA_W = 8,
  parameter int FW     = DATA_W + 2,
  parameter int NW     = 4
) (
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        len_sel,
  input  logic              par_en,
  input  logic              par_odd,
  output logic [FW-1:0]     frame,
  output logic [NW-1:0]     nbits
);
  int   nd;
  logic parity;

  always_comb begin
    nd     = 5 + int'(len_sel);
    frame  = '1;
    frame[0] = 1'b0;
    parity = par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nd) begin
        frame[i+1] = data[i];
        parity     = parity ^ data[i];
      end
    end
    for (int j = 1; j < FW; j++) begin
      if (par_en && j == nd + 1) frame[j] = parity;
    end
    nbits = NW'(1 + nd + (par_en ? 1 : 0));
  end
endmodule

// File: rtl/frac_stop_tx.sv
module frac_stop_tx #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic [1:0]        char_len,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [3:0]        stop_code,
  input  logic              cts_en,
  input  logic              cts_n,
  input  logic              ext1x,
  output logic              txd,
  output logic              tx_empty
);
  import frac_tx_pkg::*;

  localparam int FW = DATA_W + 2;
  localparam int NW = $clog2(FW + 1);
  localparam int CW = $clog2(2 * OVS);

  tx_state_t       state;
  logic [FW-1:0]   sh;
  logic [NW-1:0]   nleft;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   stop_q;
  logic            x1_q;
  logic            txd_q;
  logic            empty_q;

  logic            cts_sync_n;
  logic [FW-1:0]   frame;
  logic [NW-1:0]   nbits;
  logic [CW-1:0]   stop_ticks;
  logic [CW-1:0]   bit_last;
  logic            go;

  frac_tx_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_n(cts_n), .sync_n(cts_sync_n)
  );

  frac_tx_framer #(.DATA_W(DATA_W), .FW(FW), .NW(NW)) u_frame (
    .data(in_data), .len_sel(char_len), .par_en(par_en), .par_odd(par_odd),
    .frame(frame), .nbits(nbits)
  );

  frac_tx_stop_len #(.OVS(OVS), .CW(CW)) u_stop (
    .code(stop_code), .len5(char_len == 2'b00), .x1(ext1x), .ticks(stop_ticks)
  );

  assign bit_last = x1_q ? '0 : CW'(OVS - 1);
  assign go       = tick16 && (!cts_en || !cts_sync_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      sh      <= '1;
      nleft   <= '0;
      cnt     <= '0;
      stop_q  <= '0;
      x1_q    <= 1'b0;
      txd_q   <= 1'b1;
      empty_q <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (in_valid) begin
            sh      <= frame;
            nleft   <= nbits;
            stop_q  <= stop_ticks;
            x1_q    <= ext1x;
            empty_q <= 1'b0;
            state   <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (go) begin
            txd_q <= sh[0];
            sh    <= {1'b1, sh[FW-1:1]};
            nleft <= nleft - NW'(1);
            cnt   <= '0;
            state <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (tick16) begin
            if (cnt == bit_last) begin
              cnt <= '0;
              if (nleft == '0) begin
                txd_q <= 1'b1;
                state <= ST_STOP;
              end else begin
                txd_q <= sh[0];
                sh    <= {1'b1, sh[FW-1:1]};
                nleft <= nleft - NW'(1);
              end
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        ST_STOP: begin
          if (tick16) begin
            if (cnt == stop_q - CW'(1)) begin
              state   <= ST_IDLE;
              empty_q <= 1'b1;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready = (state == ST_IDLE);
  assign txd      = txd_q;
  assign tx_empty = empty_q;
endmodule

// File: rtl/frac_stop_tx_chk.sv
module frac_stop_tx_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          tick16,
  input logic          in_valid,
  input logic          in_ready,
  input logic          txd,
  input logic          tx_empty,
  input logic          cts_en,
  input logic          ext1x,
  input logic [1:0]    state,
  input logic          cts_q,
  input logic [CW-1:0] stop_ticks
);
  import frac_tx_pkg::*;

  assert_idle_marks_R9: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (tx_empty && txd));

  assert_accept_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (!in_ready && !tx_empty));

  assert_cts_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && cts_en && cts_q) |=> (state == ST_HOLD && txd));

  assert_tick_only_R2: assert property (@(posedge clk) disable iff (rst)
    !tick16 |=> $stable(txd));

  assert_onex_stop_R6: assert property (@(posedge clk) disable iff (rst)
    ext1x |-> (stop_ticks == CW'(1) || stop_ticks == CW'(2)));

  assert_empty_end_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_empty) |-> (in_ready && $past(state) == ST_STOP));
endmodule

bind frac_stop_tx frac_stop_tx_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .tick16(tick16), .in_valid(in_valid),
  .in_ready(in_ready), .txd(txd), .tx_empty(tx_empty), .cts_en(cts_en),
  .ext1x(ext1x), .state(state), .cts_q(cts_sync_n), .stop_ticks(stop_ticks)
);

// File: tb/frac_stop_tx_tb_top.sv
module frac_stop_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic [1:0] char_len = 2'b11;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic [3:0] stop_code = 4'h7;
  logic       cts_en = 1'b0;
  logic       cts_n = 1'b1;
  logic       ext1x = 1'b0;
  logic       txd;
  logic       tx_empty;

  int    total = 0;
  int    bad = 0;
  int    tick_div = 1;
  int    tcnt = 0;
  int    wd = 0;
  string cur_req = "R2";

  always #5 clk = ~clk;

  frac_stop_tx dut_i (
    .clk(clk), .rst(rst), .tick16(tick16), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .char_len(char_len),
    .par_en(par_en), .par_odd(par_odd), .stop_code(stop_code),
    .cts_en(cts_en), .cts_n(cts_n), .ext1x(ext1x), .txd(txd),
    .tx_empty(tx_empty)
  );

  function automatic int exp_stop(input int code, input int len, input bit x1);
    if (x1) return (code >= 8) ? 2 : 1;
    if (code < 8) return 9 + code + ((len == 0) ? 8 : 0);
    return 16 + (code - 7);
  endfunction

  // behavioural reference: 0 idle, 1 waiting, 2 frame bits, 3 stop
  int  ms = 0;
  int  mq[$];
  int  mcnt = 0;
  int  msl = 0;
  int  mbl = 16;
  bit  m_txd = 1'b1;
  bit  m_rdy = 1'b1;
  bit  m_emp = 1'b1;
  bit  c1 = 1'b1;
  bit  c2 = 1'b1;

  always @(posedge clk) begin
    if (rst) begin
      ms = 0; mq.delete(); mcnt = 0; m_txd = 1; m_emp = 1; c1 = 1; c2 = 1;
    end else begin
      case (ms)
        0: if (in_valid) begin
          int p;
          mq.delete();
          mq.push_back(0);
          p = par_odd;
          for (int i = 0; i < 5 + int'(char_len); i++) begin
            mq.push_back(int'(in_data[i]));
            p = p ^ int'(in_data[i]);
          end
          if (par_en) mq.push_back(p);
          msl   = exp_stop(int'(stop_code), int'(char_len), ext1x);
          mbl   = ext1x ? 1 : 16;
          m_emp = 0;
          ms    = 1;
        end
        1: if (tick16 && (!cts_en || c2 == 1'b0)) begin
          m_txd = mq.pop_front()[0];
          mcnt = 0;
          ms = 2;
        end
        2: if (tick16) begin
          mcnt++;
          if (mcnt == mbl) begin
            mcnt = 0;
            if (mq.size() == 0) begin m_txd = 1; ms = 3; end
            else m_txd = mq.pop_front()[0];
          end
        end
        default: if (tick16) begin
          mcnt++;
          if (mcnt == msl) begin ms = 0; m_emp = 1; end
        end
      endcase
      c2 = c1;
      c1 = cts_n;
    end
    m_rdy = (ms == 0);
  end

  always @(negedge clk) begin
    tcnt++;
    tick16 <= ((tcnt % tick_div) == 0);
  end

  always @(negedge clk) begin
    if (!rst) begin
      total++;
      if (txd !== m_txd) begin
        bad++; $display("FAIL %s txd act=%b exp=%b t=%0t", cur_req, txd, m_txd, $time);
      end
      total++;
      if (in_ready !== m_rdy) begin
        bad++; $display("FAIL R9 in_ready act=%b exp=%b t=%0t", in_ready, m_rdy, $time);
      end
      total++;
      if (tx_empty !== m_emp) begin
        bad++; $display("FAIL R9 tx_empty act=%b exp=%b t=%0t", tx_empty, m_emp, $time);
      end
    end
  end

  always @(negedge clk) begin
    wd++;
    if (wd > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp<150000", wd);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++; $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic offer(input logic [7:0] d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!(tx_empty && in_ready)) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d);
    offer(d);
    wait_done();
  endtask

  task automatic measure_stop(input int code, input int len, input bit x1, input string req);
    int n = 0;
    bit seen = 0;
    stop_code = 4'(code); char_len = 2'(len); ext1x = x1; par_en = 0; tick_div = 1;
    offer(8'h00);
    forever begin
      @(negedge clk);
      if (tx_empty) break;
      if (!txd) seen = 1;
      else if (seen) n++;
    end
    check(req, n, exp_stop(code, len, x1));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 txd", int'(txd), 1);
    check("R1 in_ready", int'(in_ready), 1);
    check("R1 tx_empty", int'(tx_empty), 1);

    // R2: lengths and bit order with tick every cycle and every third cycle
    cur_req = "R2";
    for (int l = 0; l < 4; l++) begin
      char_len = 2'(l); send(8'hA5); send(8'h3C);
    end
    tick_div = 3;
    char_len = 2'b11; send(8'h81); send(8'h5E);
    tick_div = 1;

    // R3: parity settings
    cur_req = "R3";
    par_en = 1;
    for (int k = 0; k < 4; k++) begin
      par_odd = k[0]; char_len = 2'(k + 1);
      send(8'h6B); send(8'hF0);
    end
    par_en = 0;

    // R4, R5, R6: stop period lengths measured on the line
    cur_req = "R4";
    measure_stop(0, 3, 0, "R4 code0");
    measure_stop(7, 2, 0, "R4 code7");
    measure_stop(8, 1, 0, "R4 code8");
    measure_stop(15, 3, 0, "R4 code15");
    cur_req = "R5";
    measure_stop(0, 0, 0, "R5 code0 len5");
    measure_stop(7, 0, 0, "R5 code7 len5");
    measure_stop(9, 0, 0, "R5 code9 len5");
    cur_req = "R6";
    measure_stop(3, 3, 1, "R6 code3 1x");
    measure_stop(12, 1, 1, "R6 code12 1x");
    char_len = 2'b11; stop_code = 4'h7;
    send(8'h96); send(8'h2D);
    ext1x = 0;

    // R9: valid pulse mid-frame is ignored
    cur_req = "R9";
    offer(8'h55);
    repeat (40) @(negedge clk);
    in_valid = 1; in_data = 8'hFF;
    @(negedge clk);
    in_valid = 0;
    wait_done();

    // R7: gating holds the character while clear-to-send is high
    cur_req = "R7";
    cts_en = 1; cts_n = 1;
    offer(8'h0F);
    repeat (40) @(negedge clk);
    check("R7 line held", int'(txd), 1);
    check("R7 still waiting", int'(tx_empty), 0);
    cts_n = 0;
    wait_done();
    cts_en = 0; cts_n = 1;
    send(8'hC3);
    check("R7 gating off", int'(tx_empty), 1);

    // R8: clear-to-send change mid-frame
    cur_req = "R8";
    cts_en = 1; cts_n = 0;
    offer(8'h99);
    repeat (30) @(negedge clk);
    cts_n = 1;
    wait_done();
    check("R8 frame finished", int'(tx_empty), 1);
    cts_en = 0;

    // R10: start waits for a tick
    cur_req = "R10";
    tick_div = 7;
    send(8'h12); send(8'hE7);
    tick_div = 1;

    repeat (5) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule